// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block holds the software-visible state of an interrupt routing controller with a parameterised number of input pins (24 by default). Software sees only two 32-bit locations on a simple register bus: a selector location and a data location. It first writes an internal register number into the selector. It then reads or writes the data location, which acts on the register that the selector names. Behind the window sit a controller identifier, a read-only version word, an arbitration word that mirrors the identifier, and one 64-bit routing entry per pin. Each entry is reached as two 32-bit halves.

Each routing entry is laid out as follows: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote-IRR in 14, trigger mode in 15, mask in 16, and destination in 63:56. The whole table is brought out flat for the pin-servicing logic. After each accepted entry write, the block pulses an update strobe that carries the entry index. The pin logic uses it to re-examine a pin that is still pending. The bus and the strobe are plain control signals with no back-pressure. Writes are accepted on every clock edge where the write enable is high. Read data is combinational from the current address and state.

Top module: `irq_route_regwin`

## Requirements
- R1: After reset the selector reads 0, the identifier reads 0, every entry's low half reads 0x00010000 (only the mask bit, bit 16, set) and every high half reads 0.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the selector and offset 0x10 is the data window. Reads at any other offset return 0, and writes there change nothing.
- R3: A write to offset 0x00 stores all 32 data bits in the selector, and a read of offset 0x00 returns them.
- R4: With selector 1, the window reads {8'h00, PINS-1, 8'h00, VERSION} (0x00170011 by default), and writes there are ignored.
- R5: With selector 0, a window write stores data bits 27:24 as the identifier. Selectors 0 and 2 both read it back in bits 27:24 with all other bits 0. Writes with selector 2 are ignored.
- R6: For a selector S of 0x10 or more, the entry index is (S-0x10)>>1. An odd S reaches bits 63:32 and an even S reaches bits 31:0. Writing one entry leaves every other entry unchanged.
- R7: A window write to a low half stores the data but forces remote-IRR (bit 14) to 0. A write to a high half leaves the low half unchanged.
- R8: Selectors whose index is at or beyond PINS, and selectors 3 to 0x0F, read 0 through the window, and window writes with them change no state.
- R9: One cycle after each accepted entry write, upd_valid is high for one cycle with upd_index equal to the entry index. upd_valid stays low after any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (32) | Byte address; only bits 7:0 are decoded |
| bus_wr_en | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| entry_table | output | PINS*64 | All routing entries, entry i in bits 64*i+63 : 64*i |
| upd_valid | output | 1 | One-cycle pulse after an entry write |
| upd_index | output | IDX_W (5) | Index of the entry that was written |

## Verification
On every cycle the embedded assertions check three things. Every update pulse must trace back to a window write on the previous edge, with an index inside the table. A low-half write must leave remote-IRR clear, and a high-half write must leave the low half unchanged. Writes to unknown offsets, to out-of-range selectors, or that do not target the identifier must leave the table, selector and identifier unchanged. Only the bench's scenarios can show the decode values themselves: the exact version word, the mirroring of the identifier into the arbitration word, the index arithmetic on every pin with distinct data patterns and no cross-talk, address aliasing through the high address bits, and the strobe's index and one-cycle width.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam int DATA_W     = 32;
  localparam int ENTRY_W    = 64;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam int SEL_ID     = 0;
  localparam int SEL_VER    = 1;
  localparam int SEL_ARB    = 2;
  localparam int SEL_ENTRY0 = 16;
  localparam int RIRR_BIT   = 14;
  localparam int MASK_BIT   = 16;

  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_ENT,
    K_NONE
  } sel_kind_e;
endpackage

// File: rtl/irw_select_decode.sv
module irw_select_decode
  import irw_pkg::*;
#(
  parameter int PINS  = 24,
  parameter int IDX_W = $clog2(PINS)
) (
  input  logic [DATA_W-1:0] sel,
  output sel_kind_e         kind,
  output logic              half_hi,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [DATA_W-1:0] ENT_LO = DATA_W'(SEL_ENTRY0);
  localparam logic [DATA_W-1:0] ENT_HI = DATA_W'(SEL_ENTRY0 + 2 * PINS);

  logic [DATA_W-1:0] off;
  logic              unused_off;

  assign off        = sel - ENT_LO;
  assign unused_off = &{1'b0, off[DATA_W-1:IDX_W+1]};
  assign half_hi    = off[0];
  assign idx        = off[IDX_W:1];

  always_comb begin
    if (sel == DATA_W'(SEL_ID))                    kind = K_ID;
    else if (sel == DATA_W'(SEL_VER))              kind = K_VER;
    else if (sel == DATA_W'(SEL_ARB))              kind = K_ARB;
    else if (sel >= ENT_LO && sel < ENT_HI)        kind = K_ENT;
    else                                           kind = K_NONE;
  end
endmodule

// File: rtl/irw_entry_bank.sv
module irw_entry_bank
  import irw_pkg::*;
#(
  parameter int PINS  = 24,
  parameter int IDX_W = $clog2(PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_hi,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [PINS*ENTRY_W-1:0] table_flat
);
  localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << MASK_BIT;

  for (genvar gi = 0; gi < PINS; gi++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    logic               hit;

    assign hit = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= RST_ENTRY;
      end else if (hit) begin
        if (wr_hi) ent_q[63:32] <= wdata;
        else       ent_q[31:0]  <= {wdata[31:RIRR_BIT+1], 1'b0, wdata[RIRR_BIT-1:0]};
      end
    end

    assign table_flat[gi*ENTRY_W +: ENTRY_W] = ent_q;

    // R7
    lo_write_clears_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !wr_hi) |=> !table_flat[gi*ENTRY_W + RIRR_BIT]);

    // R7
    hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr_hi) |=> $stable(table_flat[gi*ENTRY_W +: 32]));

    // R6
    other_entry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx != IDX_W'(gi)) |=> $stable(table_flat[gi*ENTRY_W +: ENTRY_W]));
  end
endmodule

// File: rtl/irw_read_mux.sv
module irw_read_mux
  import irw_pkg::*;
#(
  parameter int          PINS    = 24,
  parameter int          IDX_W   = $clog2(PINS),
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic [7:0]              addr_lo,
  input  logic [DATA_W-1:0]       sel,
  input  logic [3:0]              ctl_id,
  input  sel_kind_e               kind,
  input  logic                    half_hi,
  input  logic [IDX_W-1:0]        idx,
  input  logic [PINS*ENTRY_W-1:0] table_flat,
  output logic [DATA_W-1:0]       rdata
);
  localparam logic [7:0] PIN_MAX = 8'(PINS - 1);

  logic [ENTRY_W-1:0] ent;
  logic [DATA_W-1:0]  win;

  always_comb begin
    ent = '0;
    if (int'(idx) < PINS) ent = table_flat[int'(idx)*ENTRY_W +: ENTRY_W];
  end

  always_comb begin
    unique case (kind)
      K_ID, K_ARB: win = {4'h0, ctl_id, 24'h0};
      K_VER:       win = {8'h00, PIN_MAX, 8'h00, VERSION};
      K_ENT:       win = half_hi ? ent[63:32] : ent[31:0];
      default:     win = '0;
    endcase
  end

  always_comb begin
    if (addr_lo == OFS_SEL)      rdata = sel;
    else if (addr_lo == OFS_WIN) rdata = win;
    else                         rdata = '0;
  end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
  import irw_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter int         ADDR_W  = 32,
  parameter logic [7:0] VERSION = 8'h11,
  parameter int         IDX_W   = $clog2(PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr_en,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [PINS*ENTRY_W-1:0] entry_table,
  output logic                    upd_valid,
  output logic [IDX_W-1:0]        upd_index
);
  logic [7:0]        addr_lo;
  logic              unused_addr;
  logic [DATA_W-1:0] sel_q;
  logic [3:0]        id_q;
  sel_kind_e         kind;
  logic              half_hi;
  logic [IDX_W-1:0]  idx;
  logic              sel_wr, win_wr, id_wr, ent_wr;

  assign addr_lo     = bus_addr[7:0];
  assign unused_addr = &{1'b0, bus_addr[ADDR_W-1:8]};

  assign sel_wr = bus_wr_en && (addr_lo == OFS_SEL);
  assign win_wr = bus_wr_en && (addr_lo == OFS_WIN);
  assign id_wr  = win_wr && (kind == K_ID);
  assign ent_wr = win_wr && (kind == K_ENT);

  irw_select_decode #(.PINS(PINS), .IDX_W(IDX_W)) u_dec (
    .sel     (sel_q),
    .kind    (kind),
    .half_hi (half_hi),
    .idx     (idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (id_wr)  id_q  <= bus_wdata[27:24];
    end
  end

  irw_entry_bank #(.PINS(PINS), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ent_wr),
    .wr_hi      (half_hi),
    .wr_idx     (idx),
    .wdata      (bus_wdata),
    .table_flat (entry_table)
  );

  irw_read_mux #(.PINS(PINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
    .addr_lo    (addr_lo),
    .sel        (sel_q),
    .ctl_id     (id_q),
    .kind       (kind),
    .half_hi    (half_hi),
    .idx        (idx),
    .table_flat (entry_table),
    .rdata      (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_index <= '0;
    end else begin
      upd_valid <= ent_wr;
      if (ent_wr) upd_index <= idx;
    end
  end

  // R9
  upd_from_window_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ($past(bus_wr_en) && $past(bus_addr[7:0]) == OFS_WIN));

  // R9
  upd_index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (int'(upd_index) < PINS));

  // R8
  bad_select_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && kind == K_NONE) |=> ($stable(entry_table) && $stable(id_q) && $stable(sel_q)));

  // R2
  bad_offset_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && addr_lo != OFS_SEL && addr_lo != OFS_WIN)
      |=> ($stable(entry_table) && $stable(id_q) && $stable(sel_q)));

  // R5
  id_only_by_id_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && addr_lo == OFS_WIN && sel_q == 0) |=> $stable(id_q));
endmodule

// File: tb/sim_irq_route_regwin.sv
`timescale 1ns/1ps
module sim_irq_route_regwin;
  localparam int PINS  = 24;
  localparam int IDX_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [PINS*64-1:0] entry_table;
  logic              upd_valid;
  logic [IDX_W-1:0]  upd_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        seen_v, after_v;
  logic [IDX_W-1:0] seen_i;
  logic [31:0] exp_lo [PINS];
  logic [31:0] exp_hi [PINS];
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_route_regwin u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entry_table(entry_table),
    .upd_valid(upd_valid), .upd_index(upd_index)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    seen_v = upd_valid;
    seen_i = upd_index;
    @(negedge clk);
    after_v = upd_valid;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b0;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] lo_pat(input int i);
    return 32'h5A00_4000 | 32'(i) | (32'(i) << 20) | ((i % 2 == 1) ? 32'h0001_0000 : 32'h0);
  endfunction

  function automatic logic [31:0] hi_pat(input int i);
    return (32'(i + 1) * 32'h0101_0101) ^ 32'h3C00_0000;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(32'h00, rv); check("R1 select after reset", rv, 32'h0);
    rd(32'h10, rv); check("R1 id after reset", rv, 32'h0);
    for (int i = 0; i < PINS; i++) begin
      wr(32'h00, 32'h10 + 32'(2 * i));
      rd(32'h10, rv); check("R1 entry low reset", rv, 32'h0001_0000);
      wr(32'h00, 32'h11 + 32'(2 * i));
      rd(32'h10, rv); check("R1 entry high reset", rv, 32'h0);
      exp_lo[i] = 32'h0001_0000;
      exp_hi[i] = 32'h0;
    end

    // R4 version word, read only
    wr(32'h00, 32'h1);
    rd(32'h10, rv); check("R4 version", rv, {8'h00, 8'(PINS - 1), 8'h00, 8'h11});
    wr(32'h10, 32'hFFFF_FFFF);
    check("R9 no strobe on version write", 32'(seen_v), 32'h0);
    rd(32'h10, rv); check("R4 version after write", rv, 32'h0017_0011);

    // R5 identifier and arbitration mirror
    wr(32'h00, 32'h0);
    wr(32'h10, 32'hFEDC_BA98);
    check("R9 no strobe on id write", 32'(seen_v), 32'h0);
    rd(32'h10, rv); check("R5 id readback", rv, 32'h0E00_0000);
    wr(32'h00, 32'h2);
    rd(32'h10, rv); check("R5 arb mirrors id", rv, 32'h0E00_0000);
    wr(32'h10, 32'h0500_0000);
    rd(32'h10, rv); check("R5 arb write ignored", rv, 32'h0E00_0000);

    // R3 selector holds all bits
    wr(32'h00, 32'h89AB_CDEF);
    rd(32'h00, rv); check("R3 select readback", rv, 32'h89AB_CDEF);

    // R2 other offsets and aliasing
    rd(32'h20, rv); check("R2 unknown offset read", rv, 32'h0);
    wr(32'h30, 32'h1234_5678);
    rd(32'h00, rv); check("R2 unknown offset write ignored", rv, 32'h89AB_CDEF);
    wr(32'hABCD_0000, 32'h16);
    rd(32'h0000_0100, rv); check("R2 alias select", rv, 32'h16);
    rd(32'h1234_5610, rv); check("R2 alias window", rv, 32'h0001_0000);

    // R6 R7 R9 sweep over every pin
    for (int i = 0; i < PINS; i++) begin
      wr(32'h00, 32'h10 + 32'(2 * i));
      wr(32'h10, lo_pat(i));
      exp_lo[i] = lo_pat(i) & ~32'h0000_4000;
      check("R9 strobe after low write", 32'(seen_v), 32'h1);
      check("R9 strobe index", 32'(seen_i), 32'(i));
      check("R9 strobe one cycle", 32'(after_v), 32'h0);
      rd(32'h10, rv); check("R7 low write clears rirr", rv, exp_lo[i]);
      wr(32'h00, 32'h11 + 32'(2 * i));
      wr(32'h10, hi_pat(i));
      exp_hi[i] = hi_pat(i);
      check("R9 strobe index high", 32'(seen_i), 32'(i));
      rd(32'h10, rv); check("R6 high half readback", rv, exp_hi[i]);
      wr(32'h00, 32'h10 + 32'(2 * i));
      rd(32'h10, rv); check("R7 high write keeps low", rv, exp_lo[i]);
    end
    for (int i = 0; i < PINS; i++) begin
      wr(32'h00, 32'h10 + 32'(2 * i));
      rd(32'h10, rv); check("R6 final low", rv, exp_lo[i]);
      check("R6 table low", entry_table[i*64 +: 32], exp_lo[i]);
      check("R6 table high", entry_table[i*64 + 32 +: 32], exp_hi[i]);
    end

    // R8 out-of-range and reserved selectors
    wr(32'h00, 32'h10 + 32'(2 * PINS));
    wr(32'h10, 32'hFFFF_FFFF);
    check("R8 no strobe out of range", 32'(seen_v), 32'h0);
    rd(32'h10, rv); check("R8 out of range read", rv, 32'h0);
    wr(32'h00, 32'h11 + 32'(2 * PINS));
    rd(32'h10, rv); check("R8 out of range high read", rv, 32'h0);
    wr(32'h00, 32'h07);
    rd(32'h10, rv); check("R8 reserved read", rv, 32'h0);
    wr(32'h10, 32'hFFFF_FFFF);
    check("R8 no strobe reserved", 32'(seen_v), 32'h0);
    for (int i = 0; i < PINS; i++) begin
      check("R8 table unchanged low", entry_table[i*64 +: 32], exp_lo[i]);
      check("R8 table unchanged high", entry_table[i*64 + 32 +: 32], exp_hi[i]);
    end
    wr(32'h00, 32'h0);
    rd(32'h10, rv); check("R8 id unchanged", rv, 32'h0E00_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule